// File: doc/BRIEF.md
# Serial Divider Configuration Loader

This block receives configuration words for a frequency synthesizer over a three-wire serial link (data, serial clock and load strobe) and holds them in two sets of configuration registers. Bits enter a 19-bit shift register on each rising serial clock while the load strobe is low. When the load strobe rises, the final bit that was shifted in decides which register set takes the word. One set holds the reference divide ratio and four mode flags. The other set holds the swallow count and the main count.

All three serial pins are sampled by the system clock `clk_i`. They are assumed to be synchronous to that clock already, and each serial clock phase and each load phase lasts at least one system clock cycle. Edges are found by comparing each pin with its value on the previous cycle. A word whose reference ratio or main count is below the minimum divide ratio is rejected. The rejection raises an error pulse and leaves the registers as they were. Each accepted word raises a one-cycle update strobe for the register set it wrote.

Top module: `cfg_serial_port`

## Requirements
- R1: On a system clock edge where `sclk_i` is high, `sclk_i` was low on the previous cycle, and `le_i` is low, the shift register moves up one place and `sdata_i` enters bit 0. Data is sent MSB first, so the last bit sent lands in bit 0.
- R2: On a system clock edge where `le_i` is high and was low on the previous cycle, the word is transferred. If bit 0 is 1 the word goes to the reference registers. If bit 0 is 0 it goes to the counter registers.
- R3: Reference word layout: bits 14..1 are `ref_div_o`, with bit 1 as the LSB. Bit 15 is `presc_sel_o`, bit 16 is `phase_inv_o`, bit 17 is `mon_sel_o` and bit 18 is `cp_hi_o`.
- R4: Counter word layout: bits 7..1 are `swallow_o`, with bit 1 as the LSB. Bits 18..8 are `main_div_o`, with bit 8 as the LSB.
- R5: A reference word whose ratio field is below 3, or a counter word whose main field is below 3, does not change any register and raises no update strobe. Instead, `err_o` is high for exactly one cycle.
- R6: After reset, `ref_div_o` and `main_div_o` are 3. `swallow_o`, all four mode flags, both strobes and `err_o` are 0.
- R7: An accepted transfer raises `ref_upd_o` or `cnt_upd_o` for exactly one cycle, and the new field values appear in that same cycle, one system clock after the edge that saw the load rise. The two strobes are never high together.
- R8: Rising edges of `sclk_i` while `le_i` is high do not change the shift register. A later load therefore transfers the word held from before.
- R9: If `le_i` or `sclk_i` is already high when reset is released, this counts as neither a load nor a shift.
- R10: When more than 19 bits are shifted before a load, the oldest bits are lost, and only the last 19 bits are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sdata_i | input | 1 | Serial data bit |
| sclk_i | input | 1 | Serial clock, sampled by clk_i |
| le_i | input | 1 | Load strobe: shift while low, transfer on rise |
| ref_div_o | output | 14 | Reference divide ratio |
| presc_sel_o | output | 1 | Prescaler ratio select flag |
| phase_inv_o | output | 1 | Phase comparator polarity flag |
| mon_sel_o | output | 1 | Lock/monitor output select flag |
| cp_hi_o | output | 1 | Charge pump high-current flag |
| swallow_o | output | 7 | Swallow count |
| main_div_o | output | 11 | Main divide count |
| ref_upd_o | output | 1 | One-cycle pulse on reference register update |
| cnt_upd_o | output | 1 | One-cycle pulse on counter register update |
| err_o | output | 1 | One-cycle pulse on a rejected transfer |

## Verification
The shift register cannot be seen at the ports, so the hardest cases to reach are those that depend on what it holds but not on what has just been loaded. These are the serial clock edges that arrive while the load strobe is high, and the excess bits sent ahead of a word. To reach them, the stimulus first loads a known word. It then toggles the serial clock with contrasting data while the load strobe is held high, drops the strobe and raises it again, and expects the earlier word to be transferred a second time. For excess bits, extra bits are sent in front of a full word, and the loaded fields must show only the last 19 bits. Rejected words are sent between valid ones, so that the bench can see that the registers keep their old values.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  localparam int MODE_W = 4;

  // bit 0 of the packed struct is the flag nearest the ratio field
  typedef struct packed {
    logic cp_hi;
    logic mon_sel;
    logic phase_inv;
    logic presc_sel;
  } mode_t;
endpackage

// File: rtl/cfg_port_shifter.sv
module cfg_port_shifter #(
  parameter int WORD_W = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sdata_i,
  input  logic              sclk_i,
  input  logic              le_i,
  output logic [WORD_W-1:0] word_o,
  output logic              load_o
);
  logic sclk_q, le_q;
  logic [WORD_W-1:0] shreg_q;
  logic shift_en;

  assign shift_en = sclk_i & ~sclk_q & ~le_i;
  assign load_o   = le_i & ~le_q;
  assign word_o   = shreg_q;

  // history regs reset high: a pin already high at release is not an edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b1;
      le_q    <= 1'b1;
      shreg_q <= '0;
    end else begin
      sclk_q <= sclk_i;
      le_q   <= le_i;
      if (shift_en) shreg_q <= {shreg_q[WORD_W-2:0], sdata_i};
    end
  end
endmodule

// File: rtl/cfg_port_decode.sv
module cfg_port_decode
  import cfg_port_pkg::*;
#(
  parameter int REF_W   = 14,
  parameter int SWAL_W  = 7,
  parameter int MAIN_W  = 11,
  parameter int MIN_DIV = 3,
  parameter int WORD_W  = 19
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic              load_i,
  output logic              ref_we_o,
  output logic              cnt_we_o,
  output logic              reject_o,
  output logic [REF_W-1:0]  ref_div_o,
  output mode_t             mode_o,
  output logic [SWAL_W-1:0] swal_o,
  output logic [MAIN_W-1:0] main_o
);
  logic [MODE_W-1:0] mode_bits;
  logic to_ref, ref_ok, main_ok;

  for (genvar i = 0; i < MODE_W; i++) begin : g_mode
    assign mode_bits[i] = word_i[1+REF_W+i];
  end

  assign to_ref    = word_i[0];
  assign ref_div_o = word_i[REF_W:1];
  assign mode_o    = mode_t'(mode_bits);
  assign swal_o    = word_i[SWAL_W:1];
  assign main_o    = word_i[SWAL_W+MAIN_W:SWAL_W+1];

  assign ref_ok  = ref_div_o >= REF_W'(MIN_DIV);
  assign main_ok = main_o >= MAIN_W'(MIN_DIV);

  always_comb begin
    ref_we_o = 1'b0;
    cnt_we_o = 1'b0;
    reject_o = 1'b0;
    if (load_i) begin
      if (to_ref) begin
        ref_we_o = ref_ok;
        reject_o = ~ref_ok;
      end else begin
        cnt_we_o = main_ok;
        reject_o = ~main_ok;
      end
    end
  end
endmodule

// File: rtl/cfg_port_latch.sv
module cfg_port_latch #(
  parameter int             W       = 8,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= RST_VAL;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfg_port_pkg::*;
#(
  parameter int REF_W   = 14,
  parameter int SWAL_W  = 7,
  parameter int MAIN_W  = 11,
  parameter int MIN_DIV = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sdata_i,
  input  logic              sclk_i,
  input  logic              le_i,
  output logic [REF_W-1:0]  ref_div_o,
  output logic              presc_sel_o,
  output logic              phase_inv_o,
  output logic              mon_sel_o,
  output logic              cp_hi_o,
  output logic [SWAL_W-1:0] swallow_o,
  output logic [MAIN_W-1:0] main_div_o,
  output logic              ref_upd_o,
  output logic              cnt_upd_o,
  output logic              err_o
);
  localparam int WORD_W = 1 + SWAL_W + MAIN_W;
  localparam int REFL_W = REF_W + MODE_W;
  localparam int CNTL_W = MAIN_W + SWAL_W;
  localparam logic [REFL_W-1:0] REF_RST = {{MODE_W{1'b0}}, REF_W'(MIN_DIV)};
  localparam logic [CNTL_W-1:0] CNT_RST = {MAIN_W'(MIN_DIV), {SWAL_W{1'b0}}};

  logic [WORD_W-1:0] word;
  logic              load, ref_we, cnt_we, reject;
  logic [REF_W-1:0]  dec_ref;
  mode_t             dec_mode, mode_q;
  logic [SWAL_W-1:0] dec_swal;
  logic [MAIN_W-1:0] dec_main;
  logic [REFL_W-1:0] ref_q;
  logic [CNTL_W-1:0] cnt_q;

  cfg_port_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk_i, .rst_ni, .sdata_i, .sclk_i, .le_i,
    .word_o(word), .load_o(load)
  );

  cfg_port_decode #(
    .REF_W(REF_W), .SWAL_W(SWAL_W), .MAIN_W(MAIN_W),
    .MIN_DIV(MIN_DIV), .WORD_W(WORD_W)
  ) u_dec (
    .word_i(word), .load_i(load),
    .ref_we_o(ref_we), .cnt_we_o(cnt_we), .reject_o(reject),
    .ref_div_o(dec_ref), .mode_o(dec_mode),
    .swal_o(dec_swal), .main_o(dec_main)
  );

  cfg_port_latch #(.W(REFL_W), .RST_VAL(REF_RST)) u_ref_latch (
    .clk_i, .rst_ni, .we_i(ref_we),
    .d_i({dec_mode, dec_ref}), .q_o(ref_q)
  );

  cfg_port_latch #(.W(CNTL_W), .RST_VAL(CNT_RST)) u_cnt_latch (
    .clk_i, .rst_ni, .we_i(cnt_we),
    .d_i({dec_main, dec_swal}), .q_o(cnt_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_upd_o <= 1'b0;
      cnt_upd_o <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      ref_upd_o <= ref_we;
      cnt_upd_o <= cnt_we;
      err_o     <= reject;
    end
  end

  assign ref_div_o   = ref_q[REF_W-1:0];
  assign mode_q      = mode_t'(ref_q[REFL_W-1:REF_W]);
  assign presc_sel_o = mode_q.presc_sel;
  assign phase_inv_o = mode_q.phase_inv;
  assign mon_sel_o   = mode_q.mon_sel;
  assign cp_hi_o     = mode_q.cp_hi;
  assign swallow_o   = cnt_q[SWAL_W-1:0];
  assign main_div_o  = cnt_q[CNTL_W-1:SWAL_W];
endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk #(
  parameter int REF_W   = 14,
  parameter int SWAL_W  = 7,
  parameter int MAIN_W  = 11,
  parameter int MIN_DIV = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              le_i,
  input logic [REF_W-1:0]  ref_div_o,
  input logic              presc_sel_o,
  input logic              cp_hi_o,
  input logic [SWAL_W-1:0] swallow_o,
  input logic [MAIN_W-1:0] main_div_o,
  input logic              ref_upd_o,
  input logic              cnt_upd_o,
  input logic              err_o
);
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({ref_upd_o, cnt_upd_o, err_o}) <= 1); // R7

  AST_UPD_AFTER_LE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ref_upd_o || cnt_upd_o || err_o) |-> ($past(le_i) && !$past(le_i, 2))); // R2

  AST_REF_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_upd_o |=> !ref_upd_o); // R7

  AST_CNT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_upd_o |=> !cnt_upd_o); // R7

  AST_REF_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_upd_o |-> ($stable(ref_div_o) && $stable(presc_sel_o) && $stable(cp_hi_o))); // R5

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_upd_o |-> ($stable(main_div_o) && $stable(swallow_o))); // R5

  AST_REF_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_div_o >= REF_W'(MIN_DIV)); // R5

  AST_MAIN_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    main_div_o >= MAIN_W'(MIN_DIV)); // R5
endmodule

bind cfg_serial_port cfg_serial_port_chk #(
  .REF_W(REF_W), .SWAL_W(SWAL_W), .MAIN_W(MAIN_W), .MIN_DIV(MIN_DIV)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .le_i(le_i),
  .ref_div_o(ref_div_o), .presc_sel_o(presc_sel_o), .cp_hi_o(cp_hi_o),
  .swallow_o(swallow_o), .main_div_o(main_div_o),
  .ref_upd_o(ref_upd_o), .cnt_upd_o(cnt_upd_o), .err_o(err_o)
);

// File: tb/cfg_serial_port_tb.sv
module cfg_serial_port_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sdata = 1'b0, sclk = 1'b1, le = 1'b1;
  logic [13:0] ref_div;
  logic presc_sel, phase_inv, mon_sel, cp_hi;
  logic [6:0] swallow;
  logic [10:0] main_div;
  logic ref_upd, cnt_upd, err;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cfg_serial_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sdata_i(sdata), .sclk_i(sclk), .le_i(le),
    .ref_div_o(ref_div), .presc_sel_o(presc_sel), .phase_inv_o(phase_inv),
    .mon_sel_o(mon_sel), .cp_hi_o(cp_hi), .swallow_o(swallow),
    .main_div_o(main_div), .ref_upd_o(ref_upd), .cnt_upd_o(cnt_upd), .err_o(err)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit q[$];
  int m_ref, m_mode, m_sw, m_main, m_ru, m_cu, m_err;
  bit p_sclk, p_le;

  function automatic int word_bit(int i);
    return int'(q[18-i]);
  endfunction

  function automatic int word_field(int lo, int w);
    int v = 0;
    for (int i = w - 1; i >= 0; i--) v = (v << 1) | word_bit(lo + i);
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      for (int i = 0; i < 19; i++) q.push_back(1'b0);
      m_ref = 3; m_mode = 0; m_sw = 0; m_main = 3;
      m_ru = 0; m_cu = 0; m_err = 0;
      p_sclk = 1; p_le = 1;
    end else begin
      m_ru = 0; m_cu = 0; m_err = 0;
      if (le && !p_le) begin
        if (word_bit(0) == 1) begin
          if (word_field(1, 14) >= 3) begin
            m_ref = word_field(1, 14); m_mode = word_field(15, 4); m_ru = 1;
          end else m_err = 1;
        end else begin
          if (word_field(8, 11) >= 3) begin
            m_sw = word_field(1, 7); m_main = word_field(8, 11); m_cu = 1;
          end else m_err = 1;
        end
      end
      if (sclk && !p_sclk && !le) begin
        q.push_back(sdata);
        void'(q.pop_front());
      end
      p_sclk = sclk; p_le = le;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    check("R3 ref_div model", int'(ref_div), m_ref);
    check("R3 mode model", int'({cp_hi, mon_sel, phase_inv, presc_sel}), m_mode);
    check("R4 swallow model", int'(swallow), m_sw);
    check("R4 main model", int'(main_div), m_main);
    check("R7 ref_upd model", int'(ref_upd), m_ru);
    check("R7 cnt_upd model", int'(cnt_upd), m_cu);
    check("R5 err model", int'(err), m_err);
  end

  function automatic logic [18:0] ref_word(int r, bit sw, bit fc, bit lds, bit cs);
    return {cs, lds, fc, sw, 14'(r), 1'b1};
  endfunction

  function automatic logic [18:0] cnt_word(int a, int n);
    return {11'(n), 7'(a), 1'b0};
  endfunction

  task automatic shift_bit(bit b);
    @(negedge clk); sdata = b; sclk = 1'b0;
    @(negedge clk); sclk = 1'b1;
    @(negedge clk); sclk = 1'b0;
  endtask

  task automatic send(logic [18:0] w);
    for (int i = 18; i >= 0; i--) shift_bit(w[i]);
  endtask

  int g_ru, g_cu, g_err;
  task automatic load();
    @(negedge clk); le = 1'b1;
    @(negedge clk); g_ru = ref_upd; g_cu = cnt_upd; g_err = err;
    @(negedge clk); le = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;                       // le and sclk high at release
    repeat (3) @(negedge clk);
    check("R6 ref_div reset", ref_div, 3);
    check("R6 main reset", main_div, 3);
    check("R6 swallow reset", swallow, 0);
    check("R6 modes reset", {cp_hi, mon_sel, phase_inv, presc_sel}, 0);
    check("R9 no strobe at release", ref_upd | cnt_upd | err, 0);
    le = 1'b0; sclk = 1'b0;

    send(ref_word(1000, 1, 0, 1, 0)); load();
    check("R2 ref strobe", g_ru, 1);
    check("R7 cnt strobe idle", g_cu, 0);
    check("R3 ratio", ref_div, 1000);
    check("R3 flags", {cp_hi, mon_sel, phase_inv, presc_sel}, 4'b0101);
    @(negedge clk) check("R7 strobe one cycle", ref_upd, 0);

    send(cnt_word(5, 300)); load();
    check("R2 cnt strobe", g_cu, 1);
    check("R4 swallow", swallow, 5);
    check("R4 main", main_div, 300);
    check("R2 ref untouched", ref_div, 1000);

    send(ref_word(2, 1, 1, 1, 1)); load();
    check("R5 ref reject err", g_err, 1);
    check("R5 ref reject no strobe", g_ru, 0);
    check("R5 ref kept", ref_div, 1000);
    check("R5 flags kept", presc_sel, 1);
    @(negedge clk) check("R5 err one cycle", err, 0);

    send(cnt_word(127, 0)); load();
    check("R5 cnt reject err", g_err, 1);
    check("R5 swallow kept", swallow, 5);

    send(ref_word(3, 1, 1, 1, 1)); load();
    check("R5 ratio 3 accepted", g_ru, 1);
    check("R3 ratio min", ref_div, 3);
    check("R3 all flags", {cp_hi, mon_sel, phase_inv, presc_sel}, 4'b1111);

    send(ref_word(16383, 0, 1, 0, 0)); load();
    check("R3 ratio max", ref_div, 16383);
    check("R3 phase flag only", {cp_hi, mon_sel, phase_inv, presc_sel}, 4'b0010);

    for (int i = 0; i < 6; i++) shift_bit(1'b1);
    send(cnt_word(0, 2047)); load();
    check("R10 extra bits main", main_div, 2047);
    check("R10 extra bits swallow", swallow, 0);

    send(cnt_word(77, 1234)); load();
    @(negedge clk); le = 1'b1;
    for (int i = 0; i < 19; i++) begin     // edges while le high
      @(negedge clk); sdata = 1'b1; sclk = 1'b1;
      @(negedge clk); sclk = 1'b0;
    end
    check("R8 no load while held", cnt_upd, 0);
    @(negedge clk); le = 1'b0;
    load();
    check("R8 reload strobe", g_cu, 1);
    check("R8 reload main", main_div, 1234);
    check("R1 reload swallow", swallow, 77);

    // reset with sclk and le high again
    @(negedge clk); le = 1'b1; sclk = 1'b1; rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R9 no load after release", ref_upd | cnt_upd | err, 0);
    check("R6 ref after reset", ref_div, 3);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule